// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the step sequencer for a processor datapath that takes several clock cycles per instruction. It reads the 6-bit operation code held in the datapath's instruction register. From that code it walks a fixed graph of ten steps. Every step drives its own set of datapath strobes and multiplexer selects. The outputs depend only on the current step (a Moore machine), so the opcode affects only which step comes next.

Every instruction starts with a fetch step and then a decode step. After decode the machine branches by opcode into one of five paths:

- load: three more steps
- store: two more steps
- register-to-register ALU operation: two more steps
- conditional branch: one more step
- jump: one more step

Each path ends by returning to fetch. An opcode the machine does not recognise sends it from decode straight back to fetch, and nothing is written on the way. A parameter chooses how the step register is built: a dense binary register, or a one-hot register.

Top module: `ctrl_fsm`

## Requirements

The output bundle is written as {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_ld, wb_sel, rf_wr, dst_sel, alu_a_sel, alu_b_sel[1:0], alu_op[1:0], pc_src[1:0]}. Any output not named for a step is 0 in that step.

- R1: While rst_ni is low, the outputs show the fetch pattern at once, without waiting for a clock edge. After release, the first rising edge moves the machine to decode.
- R2: The fetch step asserts pc_wr, mem_rd and ir_ld and sets alu_b_sel=01. It always moves to decode on the next edge, whatever the opcode.
- R3: The decode step sets alu_b_sel=11 and nothing else. It dispatches to the next step by opcode:
  - 100011 (load) or 101011 (store) go to address calculation.
  - 000000 goes to ALU execute.
  - 000100 goes to branch.
  - 000010 goes to jump.
- R4: Load takes the steps fetch, decode, address calculation, memory read, write-back, fetch:
  - Address calculation: alu_a_sel=1, alu_b_sel=10.
  - Memory read: mem_rd=1, addr_sel=1.
  - Write-back: rf_wr=1, wb_sel=1.
- R5: Store takes the steps fetch, decode, address calculation, memory write, fetch. Memory write: mem_wr=1, addr_sel=1. In address calculation, opcode 101011 selects memory write and any other opcode selects memory read.
- R6: The ALU operation takes the steps fetch, decode, execute, register write, fetch:
  - Execute: alu_a_sel=1, alu_op=10.
  - Register write: rf_wr=1, dst_sel=1.
- R7: Branch takes the steps fetch, decode, compare, fetch. Compare: alu_a_sel=1, alu_op=01, pc_wr_cond=1, pc_src=01.
- R8: Jump takes the steps fetch, decode, jump, fetch. Jump: pc_wr=1, pc_src=10.
- R9: Any other opcode in decode returns the machine to fetch on the next edge. No write strobe (pc_wr, pc_wr_cond, mem_wr, rf_wr) is raised before that fetch.
- R10: In every step at most one of pc_wr, pc_wr_cond, mem_wr and rf_wr is high, and mem_rd and mem_wr are never high together.
- R11: The opcode is ignored in every step except decode and address calculation.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, forces fetch |
| opcode_i | input | 6 | Opcode field from the instruction register |
| pc_wr_o | output | 1 | Unconditional program counter write |
| pc_wr_cond_o | output | 1 | Program counter write gated by the ALU zero flag |
| addr_sel_o | output | 1 | Memory address source: 0 = program counter, 1 = ALU result register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| ir_ld_o | output | 1 | Instruction register load |
| wb_sel_o | output | 1 | Register write data: 0 = ALU result, 1 = memory data |
| rf_wr_o | output | 1 | Register file write strobe |
| dst_sel_o | output | 1 | Destination register field: 0 = second source field, 1 = destination field |
| alu_a_sel_o | output | 1 | ALU operand A: 0 = program counter, 1 = register A |
| alu_b_sel_o | output | 2 | ALU operand B: 00 = register B, 01 = constant 4, 10 = immediate, 11 = shifted immediate |
| alu_op_o | output | 2 | ALU class: 00 = add, 01 = subtract, 10 = by function field |
| pc_src_o | output | 2 | Next PC source: 00 = ALU, 01 = ALU result register, 10 = jump target |

## Verification

Every step has a distinct output pattern, so a wrong internal step shows up in the first cycle the machine enters it.

- A wrong dispatch from decode shows the wrong path's pattern one edge after decode.
- A broken return edge shows as a missing fetch pattern one edge after the last step of a path.
- A corrupted strobe in a step shows directly in that step.

The bench therefore compares the full output pattern in every cycle of every path. It also checks that an opcode changed in the middle of a path has no effect, and that reset forces the fetch pattern without a clock edge.

// File: rtl/ctrl_fsm_pkg.sv
package ctrl_fsm_pkg;
  localparam int unsigned NUM_STEPS = 10;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MRD    = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MWR    = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RFWR   = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } step_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_ld;
    logic       wb_sel;
    logic       rf_wr;
    logic       dst_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
  } ctrl_t;

  localparam logic [1:0] BSEL_REG  = 2'b00;
  localparam logic [1:0] BSEL_FOUR = 2'b01;
  localparam logic [1:0] BSEL_IMM  = 2'b10;
  localparam logic [1:0] BSEL_SHF  = 2'b11;
  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNC  = 2'b10;
  localparam logic [1:0] PSRC_ALU  = 2'b00;
  localparam logic [1:0] PSRC_REG  = 2'b01;
  localparam logic [1:0] PSRC_JMP  = 2'b10;
endpackage

// File: rtl/ctrl_fsm_next.sv
module ctrl_fsm_next
  import ctrl_fsm_pkg::*;
#(
  parameter int unsigned      OPC_W     = 6,
  parameter logic [OPC_W-1:0] OPC_ALU   = 6'b000000,
  parameter logic [OPC_W-1:0] OPC_LOAD  = 6'b100011,
  parameter logic [OPC_W-1:0] OPC_STORE = 6'b101011,
  parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100,
  parameter logic [OPC_W-1:0] OPC_JMP   = 6'b000010
) (
  input  step_e             step_q_i,
  input  logic [OPC_W-1:0]  opcode_i,
  output step_e             step_d_o
);
  always_comb begin
    step_d_o = ST_FETCH;
    unique case (step_q_i)
      ST_FETCH:  step_d_o = ST_DECODE;
      ST_DECODE: begin
        if (opcode_i == OPC_LOAD || opcode_i == OPC_STORE) step_d_o = ST_ADDR;
        else if (opcode_i == OPC_ALU)                      step_d_o = ST_EXEC;
        else if (opcode_i == OPC_BEQ)                      step_d_o = ST_BRANCH;
        else if (opcode_i == OPC_JMP)                      step_d_o = ST_JUMP;
        else                                               step_d_o = ST_FETCH;
      end
      // store code picks the write step, anything else reads
      ST_ADDR:   step_d_o = (opcode_i == OPC_STORE) ? ST_MWR : ST_MRD;
      ST_MRD:    step_d_o = ST_LDWB;
      ST_EXEC:   step_d_o = ST_RFWR;
      ST_LDWB, ST_MWR, ST_RFWR, ST_BRANCH, ST_JUMP: step_d_o = ST_FETCH;
      default:   step_d_o = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/ctrl_fsm_state_reg.sv
module ctrl_fsm_state_reg
  import ctrl_fsm_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  step_e step_d_i,
  output step_e step_q_o
);
  generate
    if (ONE_HOT) begin : g_onehot
      logic [NUM_STEPS-1:0] hot_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hot_q <= NUM_STEPS'(1);
        else         hot_q <= NUM_STEPS'(1) << step_d_i;
      end

      always_comb begin
        step_q_o = ST_FETCH;
        for (int i = 0; i < NUM_STEPS; i++) begin
          if (hot_q[i]) step_q_o = step_e'(STEP_W'(i));
        end
      end
    end else begin : g_binary
      step_e bin_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bin_q <= ST_FETCH;
        else         bin_q <= step_d_i;
      end

      assign step_q_o = bin_q;
    end
  endgenerate
endmodule

// File: rtl/ctrl_fsm_out.sv
module ctrl_fsm_out
  import ctrl_fsm_pkg::*;
(
  input  logic  rst_ni,
  input  step_e step_q_i,
  output ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    if (!rst_ni) begin
      // reset shows the fetch pattern without waiting for an edge
      ctrl_o.pc_wr     = 1'b1;
      ctrl_o.mem_rd    = 1'b1;
      ctrl_o.ir_ld     = 1'b1;
      ctrl_o.alu_b_sel = BSEL_FOUR;
    end else begin
      unique case (step_q_i)
        ST_FETCH: begin
          ctrl_o.pc_wr     = 1'b1;
          ctrl_o.mem_rd    = 1'b1;
          ctrl_o.ir_ld     = 1'b1;
          ctrl_o.alu_b_sel = BSEL_FOUR;
          ctrl_o.pc_src    = PSRC_ALU;
          ctrl_o.alu_op    = AOP_ADD;
        end
        ST_DECODE: begin
          ctrl_o.alu_b_sel = BSEL_SHF;
          ctrl_o.alu_op    = AOP_ADD;
        end
        ST_ADDR: begin
          ctrl_o.alu_a_sel = 1'b1;
          ctrl_o.alu_b_sel = BSEL_IMM;
          ctrl_o.alu_op    = AOP_ADD;
        end
        ST_MRD: begin
          ctrl_o.mem_rd   = 1'b1;
          ctrl_o.addr_sel = 1'b1;
        end
        ST_LDWB: begin
          ctrl_o.rf_wr  = 1'b1;
          ctrl_o.wb_sel = 1'b1;
        end
        ST_MWR: begin
          ctrl_o.mem_wr   = 1'b1;
          ctrl_o.addr_sel = 1'b1;
        end
        ST_EXEC: begin
          ctrl_o.alu_a_sel = 1'b1;
          ctrl_o.alu_b_sel = BSEL_REG;
          ctrl_o.alu_op    = AOP_FUNC;
        end
        ST_RFWR: begin
          ctrl_o.rf_wr   = 1'b1;
          ctrl_o.dst_sel = 1'b1;
        end
        ST_BRANCH: begin
          ctrl_o.alu_a_sel  = 1'b1;
          ctrl_o.alu_b_sel  = BSEL_REG;
          ctrl_o.alu_op     = AOP_SUB;
          ctrl_o.pc_wr_cond = 1'b1;
          ctrl_o.pc_src     = PSRC_REG;
        end
        ST_JUMP: begin
          ctrl_o.pc_wr  = 1'b1;
          ctrl_o.pc_src = PSRC_JMP;
        end
        default: ctrl_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ctrl_fsm.sv
module ctrl_fsm
  import ctrl_fsm_pkg::*;
#(
  parameter int unsigned      OPC_W     = 6,
  parameter logic [OPC_W-1:0] OPC_ALU   = 6'b000000,
  parameter logic [OPC_W-1:0] OPC_LOAD  = 6'b100011,
  parameter logic [OPC_W-1:0] OPC_STORE = 6'b101011,
  parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100,
  parameter logic [OPC_W-1:0] OPC_JMP   = 6'b000010,
  parameter bit               ONE_HOT   = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             pc_wr_o,
  output logic             pc_wr_cond_o,
  output logic             addr_sel_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             ir_ld_o,
  output logic             wb_sel_o,
  output logic             rf_wr_o,
  output logic             dst_sel_o,
  output logic             alu_a_sel_o,
  output logic [1:0]       alu_b_sel_o,
  output logic [1:0]       alu_op_o,
  output logic [1:0]       pc_src_o
);
  step_e step_q, step_d;
  ctrl_t ctrl;

  ctrl_fsm_next #(
    .OPC_W(OPC_W), .OPC_ALU(OPC_ALU), .OPC_LOAD(OPC_LOAD),
    .OPC_STORE(OPC_STORE), .OPC_BEQ(OPC_BEQ), .OPC_JMP(OPC_JMP)
  ) u_next (
    .step_q_i (step_q),
    .opcode_i (opcode_i),
    .step_d_o (step_d)
  );

  ctrl_fsm_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_d_i (step_d),
    .step_q_o (step_q)
  );

  ctrl_fsm_out u_out (
    .rst_ni   (rst_ni),
    .step_q_i (step_q),
    .ctrl_o   (ctrl)
  );

  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign addr_sel_o   = ctrl.addr_sel;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign ir_ld_o      = ctrl.ir_ld;
  assign wb_sel_o     = ctrl.wb_sel;
  assign rf_wr_o      = ctrl.rf_wr;
  assign dst_sel_o    = ctrl.dst_sel;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign pc_src_o     = ctrl.pc_src;
endmodule

// File: rtl/ctrl_fsm_chk.sv
module ctrl_fsm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pc_wr_o,
  input logic       pc_wr_cond_o,
  input logic       addr_sel_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       ir_ld_o,
  input logic       wb_sel_o,
  input logic       rf_wr_o,
  input logic       dst_sel_o,
  input logic       alu_a_sel_o,
  input logic [1:0] alu_b_sel_o,
  input logic [1:0] alu_op_o,
  input logic [1:0] pc_src_o
);
  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_ld_o |=> (alu_b_sel_o == 2'b11 && !ir_ld_o)); // R2

  AST_DECODE_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_b_sel_o == 2'b11) |=> (ir_ld_o || alu_a_sel_o || (pc_wr_o && pc_src_o == 2'b10))); // R3

  AST_LOAD_READ_TO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && addr_sel_o) |=> (rf_wr_o && wb_sel_o)); // R4

  AST_STORE_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> ir_ld_o); // R5

  AST_EXEC_TO_RFWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_o == 2'b10) |=> (rf_wr_o && dst_sel_o && !wb_sel_o)); // R6

  AST_RFWR_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_o |=> ir_ld_o); // R6

  AST_BRANCH_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_cond_o |=> ir_ld_o); // R7

  AST_JUMP_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_o && pc_src_o == 2'b10) |=> ir_ld_o); // R8

  AST_SINGLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pc_wr_o, pc_wr_cond_o, mem_wr_o, rf_wr_o})); // R10

  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R10
endmodule

bind ctrl_fsm ctrl_fsm_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pc_wr_o      (pc_wr_o),
  .pc_wr_cond_o (pc_wr_cond_o),
  .addr_sel_o   (addr_sel_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .ir_ld_o      (ir_ld_o),
  .wb_sel_o     (wb_sel_o),
  .rf_wr_o      (rf_wr_o),
  .dst_sel_o    (dst_sel_o),
  .alu_a_sel_o  (alu_a_sel_o),
  .alu_b_sel_o  (alu_b_sel_o),
  .alu_op_o     (alu_op_o),
  .pc_src_o     (pc_src_o)
);

// File: tb/ctrl_fsm_tb_top.sv
module ctrl_fsm_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_ld, wb_sel, rf_wr, dst_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [5:0] OP_ALU = 6'b000000, OP_LD = 6'b100011, OP_ST = 6'b101011,
                         OP_BEQ = 6'b000100, OP_J = 6'b000010, OP_BAD = 6'b111111;

  always #10 clk = ~clk; // 50 MHz

  ctrl_fsm dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode),
    .pc_wr_o(pc_wr), .pc_wr_cond_o(pc_wr_cond), .addr_sel_o(addr_sel),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .ir_ld_o(ir_ld), .wb_sel_o(wb_sel),
    .rf_wr_o(rf_wr), .dst_sel_o(dst_sel), .alu_a_sel_o(alu_a_sel),
    .alu_b_sel_o(alu_b_sel), .alu_op_o(alu_op), .pc_src_o(pc_src)
  );

  // {pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_ld,wb_sel,rf_wr,dst_sel,alu_a,alu_b,alu_op,pc_src}
  function automatic logic [15:0] exp_pat(input int s);
    case (s)
      0: return 16'b1_0_0_1_0_1_0_0_0_0_01_00_00;
      1: return 16'b0_0_0_0_0_0_0_0_0_0_11_00_00;
      2: return 16'b0_0_0_0_0_0_0_0_0_1_10_00_00;
      3: return 16'b0_0_1_1_0_0_0_0_0_0_00_00_00;
      4: return 16'b0_0_0_0_0_0_1_1_0_0_00_00_00;
      5: return 16'b0_0_1_0_1_0_0_0_0_0_00_00_00;
      6: return 16'b0_0_0_0_0_0_0_0_0_1_00_10_00;
      7: return 16'b0_0_0_0_0_0_0_1_1_0_00_00_00;
      8: return 16'b0_1_0_0_0_0_0_0_0_1_00_01_01;
      9: return 16'b1_0_0_0_0_0_0_0_0_0_00_00_10;
      default: return 16'hffff;
    endcase
  endfunction

  function automatic logic [15:0] act_pat();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_ld, wb_sel, rf_wr,
            dst_sel, alu_a_sel, alu_b_sel, alu_op, pc_src};
  endfunction

  task automatic check_step(input int s, input string req);
    n_chk++;
    if (act_pat() !== exp_pat(s)) begin
      n_bad++;
      $display("FAIL %s: step %0d outputs act=%b exp=%b", req, s, act_pat(), exp_pat(s));
    end
  endtask

  // check the current step, then advance one clock; sampling at the falling edge
  task automatic step_and_check(input int s, input string req);
    check_step(s, req);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1 check_step(0, "R1 reset pattern");
    @(negedge clk);
    check_step(0, "R1 held in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_step(1, "R1 first edge to decode");
    @(negedge clk);  // R3: opcode 0 dispatches to execute
    check_step(6, "R1 R3 dispatch after reset");
    @(negedge clk);
    @(negedge clk);
    check_step(0, "R6 back to fetch");
  endtask

  task automatic t_load();
    opcode = OP_LD;
    step_and_check(0, "R4 R2 fetch");
    step_and_check(1, "R4 R3 decode");
    step_and_check(2, "R4 address");
    step_and_check(3, "R4 read");
    step_and_check(4, "R4 writeback");
    check_step(0, "R4 return");
  endtask

  task automatic t_store();
    opcode = OP_ST;
    step_and_check(0, "R5 fetch");
    step_and_check(1, "R5 decode");
    step_and_check(2, "R5 address");
    step_and_check(5, "R5 write");
    check_step(0, "R5 return");
  endtask

  task automatic t_alu();
    opcode = OP_ALU;
    step_and_check(0, "R6 fetch");
    step_and_check(1, "R6 decode");
    step_and_check(6, "R6 execute");
    step_and_check(7, "R6 regwrite");
    check_step(0, "R6 return");
  endtask

  task automatic t_branch();
    opcode = OP_BEQ;
    step_and_check(0, "R7 fetch");
    step_and_check(1, "R7 decode");
    step_and_check(8, "R7 compare");
    check_step(0, "R7 return");
  endtask

  task automatic t_jump();
    opcode = OP_J;
    step_and_check(0, "R8 fetch");
    step_and_check(1, "R8 decode");
    step_and_check(9, "R8 jump");
    check_step(0, "R8 return");
  endtask

  task automatic t_bad_opcode();
    opcode = OP_BAD;
    step_and_check(0, "R9 R2 fetch with bad code");
    step_and_check(1, "R9 decode");
    check_step(0, "R9 back to fetch, no writes");
    opcode = 6'b001000;
    @(negedge clk);
    step_and_check(1, "R9 decode second code");
    check_step(0, "R9 second code back to fetch");
  endtask

  task automatic t_opcode_ignored();
    opcode = OP_LD;
    step_and_check(0, "R11 fetch");
    step_and_check(1, "R11 decode");
    step_and_check(2, "R11 address");
    opcode = OP_J;
    step_and_check(3, "R11 read with opcode changed");
    opcode = OP_ST;
    step_and_check(4, "R11 writeback unaffected");
    opcode = OP_BEQ;
    check_step(0, "R11 return unaffected");
    opcode = OP_ALU;
    @(negedge clk);
    step_and_check(1, "R11 decode");
    opcode = OP_LD;
    step_and_check(6, "R11 execute");
    opcode = OP_BAD;
    step_and_check(7, "R11 regwrite unaffected");
    check_step(0, "R11 return after alu");
    // R5: address step with non-store code reads memory
    opcode = OP_ST;
    @(negedge clk);
    step_and_check(1, "R5 decode");
    opcode = OP_ALU;
    step_and_check(2, "R5 address");
    check_step(3, "R5 non-store code in address reads");
    @(negedge clk);
    @(negedge clk);
    check_step(0, "R5 return after read");
  endtask

  task automatic t_reset_midway();
    opcode = OP_ALU;
    @(negedge clk);
    step_and_check(1, "R1 decode before reset");
    check_step(6, "R1 execute before reset");
    #2 rst_ni = 1'b0;
    #1 check_step(0, "R1 async reset forces fetch");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_step(1, "R1 restart to decode");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check_step(0, "R1 settled at fetch");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_store();
    t_alu();
    t_branch();
    t_jump();
    t_bad_opcode();
    t_opcode_ignored();
    t_reset_midway();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule